// File: doc/BRIEF.md
# Data Address Breakpoint Matcher

This block sits beside a processor core's load/store path and watches every data access the core makes. Software programs up to four watch addresses. For each one it also sets an enable, an access-type filter and a window size of one, two or four aligned bytes. When an access touches a watched window, the block records which watch slots fired in a status register. It also raises a trap-pending output that the core's exception logic turns into a debug trap.

An access is presented in a single cycle as a start address, a write flag and a size code. The size code covers one to eight bytes. Every byte address the access covers is compared against every slot in parallel. Any byte that falls inside a slot's window counts as a hit on that slot. Once a trap is pending, the block stops checking and leaves the status flags frozen until the core pulses the clear input.

Control is a three-state machine. `ST_OFF` means no slot is enabled and nothing is checked. `ST_WATCH` means at least one slot is enabled and accesses are checked. `ST_TRAPPED` means a hit has occurred and the trap is pending. The transitions are:
- arm: `ST_OFF` to `ST_WATCH`, when the control value in effect for the next cycle has an enable bit set.
- disarm: `ST_WATCH` to `ST_OFF`, when all enables go to zero and no hit occurs.
- hit: `ST_WATCH` to `ST_TRAPPED`, on any slot hit.
- release: `ST_TRAPPED` to `ST_WATCH`, or to `ST_OFF` when no slot is enabled, on the clear pulse.

Top module: `dbg_bkpt_matcher`

## Requirements
- R1: Register indices are as follows, and every register resets to zero. Indices 0 to 3 are the 32-bit watch addresses of slots 0 to 3. Index 4 is the hit status, with slot i in bit i of bits [3:0]. Index 5 is the 32-bit control word. Index 6 is read-only and shows trap-pending in bit 0. Reads are combinational on `reg_idx`, and a write lands at the clock edge where `reg_we` is high.
- R2: Slot i is enabled when either control bit 2i or 2i+1 is set. If control bits [7:0] are all zero, no access is checked, whatever the other fields hold.
- R3: Slot i's type field is control bits [16+4i+1:16+4i]. Type 01 matches writes only. Type 11 matches reads and writes. Types 00 and 10 never match.
- R4: Slot i's length field is control bits [16+4i+3:16+4i+2]. Length 00 matches one byte equal to the watch address. Length 01 matches the 2-byte window at the watch address with bit 0 cleared. Length 11 matches the 4-byte window with bits [1:0] cleared. Length 10 never matches.
- R5: Size code `acc_size` selects 1, 2, 4 or 8 bytes for codes 00, 01, 10 and 11. The access covers `acc_addr` up to `acc_addr`+n-1, modulo 2^32. A hit on any covered byte is a hit for the access.
- R6: On the clock edge where a checked access hits, status bit i is set for every slot that matched. Earlier bits stay set, and trap-pending rises. Both are visible in the following cycle.
- R7: While trap-pending is high, accesses are not checked and the status bits do not change except by a software write.
- R8: Trap-pending stays high until `trap_clear` is sampled high, and it is low in the next cycle. A clear while no trap is pending has no effect.
- R9: A write to the status register replaces bits [3:0] with `reg_wdata[3:0]`. Hits from an access in the same cycle are ORed on top of the written value.
- R10: An access in the same cycle as a control write is checked against the old control value. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_addr | input | 32 | Start byte address of the access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_size | input | 2 | Access size code: 1, 2, 4 or 8 bytes |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| trap_clear | input | 1 | Pulse that releases a pending trap |
| trap_pending | output | 1 | Sticky debug trap request |

## Verification
Each window size is probed at its aligned edges. The probes use a byte just inside and a byte just outside the window, which separates exact, 2-byte and 4-byte alignment from off-by-one masks. Wider accesses are chosen so that only their upper bytes reach a window. Eight bytes starting just below the top of the address space wrap into a watched low address, which shows per-byte checking with modulo addressing. Reads against write-only slots, the reserved length and type codes, and fields programmed with both enable bits clear are applied, to show that each filter can block a hit on its own. Same-cycle collisions are also applied: a hit with a status write, a hit with a control write, and accesses while trapped. These show how the priority rules are resolved.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WATCH,
        ST_TRAPPED
    } trap_state_e;

    // Type field encodings
    localparam logic [1:0] TYPE_WR_ONLY = 2'b01;
    localparam logic [1:0] TYPE_RD_WR   = 2'b11;

    // Length field encodings
    localparam logic [1:0] LEN_BYTE = 2'b00;
    localparam logic [1:0] LEN_HALF = 2'b01;
    localparam logic [1:0] LEN_WORD = 2'b11;

    function automatic logic type_allows(input logic [1:0] ty, input logic is_write);
        return (ty == TYPE_RD_WR) || ((ty == TYPE_WR_ONLY) && is_write);
    endfunction

endpackage

// File: rtl/dbg_bkpt_slot.sv
module dbg_bkpt_slot
    import dbg_bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 8,
    localparam int SIZE_W = $clog2($clog2(LANES) + 1)
) (
    input  logic [ADDR_W-1:0] watch_addr,
    input  logic [1:0]        en_pair,
    input  logic [3:0]        len_type,
    input  logic              check_en,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic [SIZE_W-1:0] acc_size,
    output logic              slot_hit
);

    logic [1:0]       len_code;
    logic [1:0]       type_code;
    logic [LANES-1:0] lane_hit;
    logic             type_ok;

    assign type_code = len_type[1:0];
    assign len_code  = len_type[3:2];
    assign type_ok   = type_allows(type_code, acc_write);

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            logic [ADDR_W-1:0] lane_addr;
            logic              lane_active;
            logic              in_window;

            assign lane_addr   = acc_addr + ADDR_W'(k);
            assign lane_active = (k < (1 << acc_size));

            always_comb begin
                unique case (len_code)
                    LEN_BYTE: in_window = (lane_addr == watch_addr);
                    LEN_HALF: in_window = (lane_addr[ADDR_W-1:1] == watch_addr[ADDR_W-1:1]);
                    LEN_WORD: in_window = (lane_addr[ADDR_W-1:2] == watch_addr[ADDR_W-1:2]);
                    default:  in_window = 1'b0;
                endcase
            end

            assign lane_hit[k] = lane_active && in_window;
        end
    endgenerate

    assign slot_hit = check_en && (|en_pair) && type_ok && (|lane_hit);

endmodule

// File: rtl/dbg_bkpt_regfile.sv
module dbg_bkpt_regfile #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    localparam int CTRL_W   = 16 + 4 * NUM_SLOTS,
    localparam int IDX_W    = $clog2(NUM_SLOTS + 3),
    localparam int EN_W     = 2 * NUM_SLOTS
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_we,
    input  logic [IDX_W-1:0]                 reg_idx,
    input  logic [ADDR_W-1:0]                reg_wdata,
    input  logic [NUM_SLOTS-1:0]             hit_vec,
    input  logic                             pend,
    output logic [ADDR_W-1:0]                reg_rdata,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0] watch_addr,
    output logic [CTRL_W-1:0]                ctrl_q,
    output logic [NUM_SLOTS-1:0]             status_q,
    output logic                             arm_next
);

    localparam int IDX_STATUS = NUM_SLOTS;
    localparam int IDX_CTRL   = NUM_SLOTS + 1;
    localparam int IDX_PEND   = NUM_SLOTS + 2;

    logic                 wr_status;
    logic                 wr_ctrl;
    logic [CTRL_W-1:0]    ctrl_next;
    logic [NUM_SLOTS-1:0] status_next;

    assign wr_status = reg_we && (int'(reg_idx) == IDX_STATUS);
    assign wr_ctrl   = reg_we && (int'(reg_idx) == IDX_CTRL);

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_addr
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    watch_addr[s] <= '0;
                end else if (reg_we && (int'(reg_idx) == s)) begin
                    watch_addr[s] <= reg_wdata;
                end
            end
        end
    endgenerate

    assign ctrl_next   = wr_ctrl ? reg_wdata[CTRL_W-1:0] : ctrl_q;
    assign arm_next    = |ctrl_next[EN_W-1:0];
    assign status_next = (wr_status ? reg_wdata[NUM_SLOTS-1:0] : status_q) | hit_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            status_q <= '0;
        end else begin
            ctrl_q   <= ctrl_next;
            status_q <= status_next;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_idx) < NUM_SLOTS) begin
            reg_rdata = watch_addr[reg_idx[$clog2(NUM_SLOTS)-1:0]];
        end else if (int'(reg_idx) == IDX_STATUS) begin
            reg_rdata[NUM_SLOTS-1:0] = status_q;
        end else if (int'(reg_idx) == IDX_CTRL) begin
            reg_rdata[CTRL_W-1:0] = ctrl_q;
        end else if (int'(reg_idx) == IDX_PEND) begin
            reg_rdata[0] = pend;
        end
    end

endmodule

// File: rtl/dbg_bkpt_fsm.sv
module dbg_bkpt_fsm
    import dbg_bkpt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        any_hit,
    input  logic        arm_next,
    input  logic        trap_clear,
    output trap_state_e state,
    output logic        check_en,
    output logic        trap_pending
);

    trap_state_e state_next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_next;
        end
    end

    always_comb begin
        state_next = state;
        unique case (state)
            ST_OFF: begin
                if (arm_next) state_next = ST_WATCH;
            end
            ST_WATCH: begin
                if (any_hit)        state_next = ST_TRAPPED;
                else if (!arm_next) state_next = ST_OFF;
            end
            ST_TRAPPED: begin
                if (trap_clear) state_next = arm_next ? ST_WATCH : ST_OFF;
            end
            default: state_next = ST_OFF;
        endcase
    end

    always_comb begin
        check_en     = 1'b0;
        trap_pending = 1'b0;
        unique case (state)
            ST_OFF:     ;
            ST_WATCH:   check_en = 1'b1;
            ST_TRAPPED: trap_pending = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/dbg_bkpt_matcher.sv
module dbg_bkpt_matcher
    import dbg_bkpt_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    parameter int LANES     = 8,
    localparam int CTRL_W   = 16 + 4 * NUM_SLOTS,
    localparam int IDX_W    = $clog2(NUM_SLOTS + 3),
    localparam int SIZE_W   = $clog2($clog2(LANES) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              trap_clear,
    output logic              trap_pending
);

    logic [NUM_SLOTS-1:0][ADDR_W-1:0] watch_addr;
    logic [CTRL_W-1:0]                ctrl_q;
    logic [NUM_SLOTS-1:0]             status_q;
    logic [NUM_SLOTS-1:0]             hit_vec;
    logic                             arm_next;
    logic                             check_en;
    logic                             slot_check;
    trap_state_e                      state;

    assign slot_check = check_en && acc_valid;

    dbg_bkpt_regfile #(
        .NUM_SLOTS(NUM_SLOTS),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .hit_vec   (hit_vec),
        .pend      (trap_pending),
        .reg_rdata (reg_rdata),
        .watch_addr(watch_addr),
        .ctrl_q    (ctrl_q),
        .status_q  (status_q),
        .arm_next  (arm_next)
    );

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            dbg_bkpt_slot #(
                .ADDR_W(ADDR_W),
                .LANES (LANES)
            ) u_slot (
                .watch_addr(watch_addr[s]),
                .en_pair   (ctrl_q[2*s +: 2]),
                .len_type  (ctrl_q[16 + 4*s +: 4]),
                .check_en  (slot_check),
                .acc_addr  (acc_addr),
                .acc_write (acc_write),
                .acc_size  (acc_size),
                .slot_hit  (hit_vec[s])
            );
        end
    endgenerate

    dbg_bkpt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_hit     (|hit_vec),
        .arm_next    (arm_next),
        .trap_clear  (trap_clear),
        .state       (state),
        .check_en    (check_en),
        .trap_pending(trap_pending)
    );

endmodule

// File: rtl/dbg_bkpt_checker.sv
module dbg_bkpt_checker #(
    parameter int NUM_SLOTS = 4,
    parameter int CTRL_W    = 32,
    parameter int IDX_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 trap_pending,
    input logic                 trap_clear,
    input logic                 reg_we,
    input logic [IDX_W-1:0]     reg_idx,
    input logic [CTRL_W-1:0]    ctrl_q,
    input logic [NUM_SLOTS-1:0] status_q
);

    logic status_wr;
    assign status_wr = reg_we && (int'(reg_idx) == NUM_SLOTS);

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pending && !trap_clear |=> trap_pending); // R8

    AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pending && trap_clear |=> !trap_pending); // R8

    AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pending && !status_wr |=> $stable(status_q)); // R7

    AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_pending && (ctrl_q[2*NUM_SLOTS-1:0] == '0) |=> !trap_pending); // R2

    AST_TRAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_pending) |-> (status_q != '0)); // R6

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !status_wr |=> ((status_q & $past(status_q)) == $past(status_q))); // R6

endmodule

bind dbg_bkpt_matcher dbg_bkpt_checker #(
    .NUM_SLOTS(NUM_SLOTS),
    .CTRL_W   (CTRL_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap_pending(trap_pending),
    .trap_clear  (trap_clear),
    .reg_we      (reg_we),
    .reg_idx     (reg_idx),
    .ctrl_q      (ctrl_q),
    .status_q    (status_q)
);

// File: tb/dbg_bkpt_matcher_test.sv
module dbg_bkpt_matcher_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_size = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = 3'd4;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        trap_clear = 1'b0;
    logic        trap_pending;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [3:0] st;
        logic       pend;
        string      tag;
    } exp_t;

    exp_t scb[$];

    always #5 clk = ~clk;

    dbg_bkpt_matcher uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_size(acc_size), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .trap_clear(trap_clear), .trap_pending(trap_pending)
    );

    // Monitor: compares the status register and trap output after each step
    initial begin
        forever begin
            @(negedge clk);
            if (scb.size() > 0) begin
                exp_t e;
                e = scb.pop_front();
                checks++;
                if (reg_rdata[3:0] !== e.st || trap_pending !== e.pend) begin
                    fails++;
                    $display("FAIL %s: status=%h pend=%b expected status=%h pend=%b",
                             e.tag, reg_rdata[3:0], trap_pending, e.st, e.pend);
                end
            end
        end
    end

    task automatic step(input logic v, input logic [31:0] a, input logic w,
                        input logic [1:0] sz, input logic we, input logic [2:0] idx,
                        input logic [31:0] wd, input logic clr,
                        input logic [3:0] es, input logic ep, input string tag);
        exp_t e;
        @(negedge clk);
        #2;
        acc_valid = v; acc_addr = a; acc_write = w; acc_size = sz;
        reg_we = we; reg_idx = idx; reg_wdata = wd; trap_clear = clr;
        @(posedge clk);
        #1;
        acc_valid = 1'b0; reg_we = 1'b0; trap_clear = 1'b0; reg_idx = 3'd4;
        e.st = es; e.pend = ep; e.tag = tag;
        scb.push_back(e);
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d,
                      input logic [3:0] es, input logic ep, input string tag);
        step(1'b0, 32'h0, 1'b0, 2'd0, 1'b1, idx, d, 1'b0, es, ep, tag);
    endtask

    task automatic acc(input logic [31:0] a, input logic w, input logic [1:0] sz,
                       input logic [3:0] es, input logic ep, input string tag);
        step(1'b1, a, w, sz, 1'b0, 3'd4, 32'h0, 1'b0, es, ep, tag);
    endtask

    // release trap and zero the status in one cycle
    task automatic clear_all(input string tag);
        step(1'b0, 32'h0, 1'b0, 2'd0, 1'b1, 3'd4, 32'h0, 1'b1, 4'h0, 1'b0, tag);
    endtask

    task automatic rd(input logic [2:0] idx, input logic [31:0] exp_v, input string tag);
        @(negedge clk);
        wait (scb.size() == 0);
        #2;
        reg_idx = idx;
        #1;
        checks++;
        if (reg_rdata !== exp_v) begin
            fails++;
            $display("FAIL %s: reg[%0d]=%h expected %h", tag, idx, reg_rdata, exp_v);
        end
        reg_idx = 3'd4;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset values
        for (int i = 0; i < 7; i++) rd(3'(i), 32'h0, "R1 reset value");
        trap_clear = 1'b0;
        checks++;
        if (trap_pending !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset pend: %b expected 0", trap_pending);
        end

        wr(3'd0, 32'h1000_0003, 4'h0, 1'b0, "R1 write slot0");
        rd(3'd0, 32'h1000_0003, "R1 readback slot0");
        acc(32'h1000_0003, 1'b1, 2'd0, 4'h0, 1'b0, "R2 no slot enabled");

        // slot0: byte, write-only, enable bit0
        wr(3'd5, 32'h0001_0001, 4'h0, 1'b0, "R1 write ctrl");
        rd(3'd5, 32'h0001_0001, "R1 readback ctrl");
        acc(32'h1000_0003, 1'b0, 2'd0, 4'h0, 1'b0, "R3 read vs write-only");
        acc(32'h1000_0002, 1'b1, 2'd0, 4'h0, 1'b0, "R4 byte neighbour");
        acc(32'h1000_0003, 1'b1, 2'd0, 4'h1, 1'b1, "R6 byte hit");
        rd(3'd6, 32'h1, "R1 pending readback");
        wr(3'd4, 32'h0, 4'h0, 1'b1, "R9 status write while pending");
        acc(32'h1000_0003, 1'b1, 2'd0, 4'h0, 1'b1, "R7 access ignored while pending");
        step(1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 3'd4, 32'h0, 1'b1, 4'h0, 1'b0, "R8 clear");
        step(1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 3'd4, 32'h0, 1'b1, 4'h0, 1'b0, "R8 idle clear");
        acc(32'h1000_0003, 1'b1, 2'd0, 4'h1, 1'b1, "R8 rearmed after clear");
        step(1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 3'd4, 32'h0, 1'b0, 4'h1, 1'b1, "R8 holds without clear");
        clear_all("R9 clear all");

        // slot1: 2-byte window, read/write, enable via high bit of pair
        wr(3'd1, 32'h2000_0005, 4'h0, 1'b0, "R1 write slot1");
        wr(3'd5, 32'h0070_0008, 4'h0, 1'b0, "R2 ctrl high enable bit");
        acc(32'h2000_0004, 1'b0, 2'd0, 4'h2, 1'b1, "R4 half window low byte");
        clear_all("R8 clear");
        acc(32'h2000_0006, 1'b0, 2'd0, 4'h0, 1'b0, "R4 half window outside");
        acc(32'h2000_0003, 1'b0, 2'd1, 4'h2, 1'b1, "R5 2-byte access upper byte");
        clear_all("R8 clear");

        // slot2: 4-byte window
        wr(3'd2, 32'h3000_000A, 4'h0, 1'b0, "R1 write slot2");
        wr(3'd5, 32'h0F00_0010, 4'h0, 1'b0, "R1 write ctrl");
        acc(32'h3000_0008, 1'b1, 2'd0, 4'h4, 1'b1, "R4 word window base");
        clear_all("R8 clear");
        acc(32'h3000_000C, 1'b1, 2'd0, 4'h0, 1'b0, "R4 word window outside");
        acc(32'h3000_0004, 1'b1, 2'd2, 4'h0, 1'b0, "R5 4-byte access below");
        acc(32'h3000_0004, 1'b1, 2'd3, 4'h4, 1'b1, "R5 8-byte access reaches");
        clear_all("R8 clear");

        // slot3: reserved length, then non-matching type
        wr(3'd3, 32'h4000_0000, 4'h0, 1'b0, "R1 write slot3");
        wr(3'd5, 32'hB000_0040, 4'h0, 1'b0, "R1 write ctrl");
        acc(32'h4000_0000, 1'b1, 2'd0, 4'h0, 1'b0, "R4 reserved length");
        wr(3'd5, 32'h2000_0040, 4'h0, 1'b0, "R1 write ctrl");
        acc(32'h4000_0000, 1'b1, 2'd0, 4'h0, 1'b0, "R3 type 10 never");

        // two slots on the same byte
        wr(3'd0, 32'h5000_0000, 4'h0, 1'b0, "R1 write slot0");
        wr(3'd1, 32'h5000_0000, 4'h0, 1'b0, "R1 write slot1");
        wr(3'd5, 32'h0033_0005, 4'h0, 1'b0, "R1 write ctrl");
        acc(32'h5000_0000, 1'b0, 2'd0, 4'h3, 1'b1, "R6 two slots hit");
        clear_all("R8 clear");

        // wrap of an 8-byte access
        wr(3'd2, 32'h0000_0002, 4'h0, 1'b0, "R1 write slot2");
        wr(3'd5, 32'h0300_0020, 4'h0, 1'b0, "R1 write ctrl");
        acc(32'hFFFF_FFFE, 1'b1, 2'd3, 4'h4, 1'b1, "R5 wrap-around");
        clear_all("R8 clear");

        // status write colliding with hit
        step(1'b1, 32'h2, 1'b0, 2'd0, 1'b1, 3'd4, 32'h1, 1'b0, 4'h5, 1'b1, "R9 write plus hit");
        clear_all("R8 clear");

        // control write colliding with access
        wr(3'd5, 32'h0, 4'h0, 1'b0, "R2 disarm");
        step(1'b1, 32'h2, 1'b0, 2'd0, 1'b1, 3'd5, 32'h0300_0020, 1'b0, 4'h0, 1'b0, "R10 old ctrl used");
        acc(32'h2, 1'b0, 2'd0, 4'h4, 1'b1, "R10 new ctrl applies");
        clear_all("R8 clear");

        wr(3'd5, 32'h0300_0000, 4'h0, 1'b0, "R2 fields without enable");
        acc(32'h2, 1'b1, 2'd0, 4'h0, 1'b0, "R2 enables clear");

        repeat (3) @(negedge clk);
        done = 1;
        summary();
    end

endmodule